// File: doc/BRIEF.md
# Operand Stack Datapath with Register-Cached Top

This block is the operand stack of a stack-oriented processor core. The two topmost stack entries live in flip-flops: `tos` is the top and `nos` is the entry just beneath it. Every entry deeper than those two is held in a small memory with one write port and one read port. Each clock cycle the block accepts one operation code from the instruction decoder. In the same cycle it performs the arithmetic, updates both registers, and either spills `nos` into the memory or refills `nos` from it. No operation stalls and none takes more than one cycle.

A stack pointer `sp` holds the address of the topmost memory-resident entry. The memory also acts as the frame of local variables. A local-variable load reads address `vp + offset`, where the base `vp` is supplied by the decoder. The result goes onto the stack top, and in the same cycle the old `nos` is written into the memory. If the address falls on one of the two register-cached slots, the register value is used in place of the stale memory word.

The memory depth must be a power of two, so all addresses wrap modulo the depth. After reset the memory region is empty and `sp` is all ones, so the first spill lands at address 0. A store is carried out by the surrounding core: it takes the value on `tos_o` and issues a pop in the same cycle.

Top module: `stack_core`

## Requirements
- R1: While reset is high, at each clock edge `tos_o` and `nos_o` become 0 and `sp_o` becomes all ones (DEPTH-1).
- R2: Op code 2 (push) loads `push_data_i` into the top, moves the old top into `nos`, writes the old `nos` to address `sp+1`, and increments `sp`.
- R3: Op code 3 (pop/store) presents the value being stored on `tos_o` before the edge. At the edge it moves `nos` into the top, refills `nos` from address `sp`, and decrements `sp`.
- R4: Op code 1 (ALU) writes the result of the selected function into the top, refills `nos` from address `sp`, and decrements `sp`.
- R5: The ALU function code selects the result, computed modulo 2^W from top T and second S: 0 gives S+T, 1 gives S-T, 2 gives S AND T, 3 gives S OR T, 4 gives S XOR T. Codes 5 to 7 behave like code 0.
- R6: Op code 4 (local load) pushes the word at address `(vp_i + var_off_i) mod DEPTH`. The old top moves into `nos`, the old `nos` is written to `sp+1`, and `sp` increments.
- R7: In a local load, an address equal to `sp+1` yields the pre-operation `nos`, and an address equal to `sp+2` yields the pre-operation top, in place of the memory word.
- R8: Op codes 0 and 5 to 7 leave `tos_o`, `nos_o` and `sp_o` unchanged.
- R9: Values spilled to the memory come back in last-in first-out order. This holds up to the case where all DEPTH memory words are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code for this cycle |
| fn_i | input | 3 | ALU function code, used by op code 1 |
| push_data_i | input | W | Value pushed by op code 2 |
| vp_i | input | AW | Local-variable frame base address |
| var_off_i | input | AW | Local-variable offset added to `vp_i` |
| tos_o | output | W | Top-of-stack register; the store value |
| nos_o | output | W | Second stack entry register |
| sp_o | output | AW | Address of the topmost memory-resident entry |

## Verification
The properties assume that the decoder never issues a pop or ALU operation while the memory region is empty. They also assume it never issues a push while all DEPTH words are occupied. Both cases would fill `nos` with a stale word or overwrite a live one. The properties further assume that a local-variable address only names a slot that currently holds a live entry. The stimulus tracks logical stack depth in its own model and enforces all three limits. It issues pops and ALU operations only when at least three logical entries exist. It fills the memory exactly to capacity and no further. It sweeps local-variable offsets only over addresses below the current depth.

// File: rtl/stk_pkg.sv
`timescale 1ns/1ps
package stk_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ALU   = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_LVAR  = 3'd4
    } stk_op_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_SUB = 3'd1,
        FN_AND = 3'd2,
        FN_OR  = 3'd3,
        FN_XOR = 3'd4
    } alu_fn_e;

    typedef enum logic [2:0] {
        TSRC_HOLD,
        TSRC_ALU,
        TSRC_PUSH,
        TSRC_NOS,
        TSRC_LVAR
    } top_src_e;

    typedef enum logic [1:0] {
        NSRC_HOLD,
        NSRC_TOP,
        NSRC_MEM
    } nos_src_e;

    typedef enum logic [1:0] {
        SP_KEEP,
        SP_UP,
        SP_DOWN
    } sp_step_e;

    typedef struct packed {
        top_src_e top_src;
        nos_src_e nos_src;
        sp_step_e sp_step;
        logic     spill;
        logic     rd_local;
    } stk_ctl_t;

    function automatic stk_ctl_t stk_decode(input logic [2:0] op);
        stk_ctl_t c;
        c.top_src  = TSRC_HOLD;
        c.nos_src  = NSRC_HOLD;
        c.sp_step  = SP_KEEP;
        c.spill    = 1'b0;
        c.rd_local = 1'b0;
        case (op)
            OP_ALU: begin
                c.top_src = TSRC_ALU;
                c.nos_src = NSRC_MEM;
                c.sp_step = SP_DOWN;
            end
            OP_PUSH: begin
                c.top_src = TSRC_PUSH;
                c.nos_src = NSRC_TOP;
                c.sp_step = SP_UP;
                c.spill   = 1'b1;
            end
            OP_POP: begin
                c.top_src = TSRC_NOS;
                c.nos_src = NSRC_MEM;
                c.sp_step = SP_DOWN;
            end
            OP_LVAR: begin
                c.top_src  = TSRC_LVAR;
                c.nos_src  = NSRC_TOP;
                c.sp_step  = SP_UP;
                c.spill    = 1'b1;
                c.rd_local = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/stk_ram.sv
`timescale 1ns/1ps
module stk_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // read path settles within the cycle so the result can land in a register at the same edge
    assign rdata = mem[raddr];
endmodule

// File: rtl/stk_alu.sv
`timescale 1ns/1ps
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   fn,
    input  logic [W-1:0] top,
    input  logic [W-1:0] sec,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            FN_SUB:  y = sec - top;
            FN_AND:  y = sec & top;
            FN_OR:   y = sec | top;
            FN_XOR:  y = sec ^ top;
            default: y = sec + top;
        endcase
    end
endmodule

// File: rtl/stk_lvar_sel.sv
`timescale 1ns/1ps
module stk_lvar_sel #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] sp,
    input  logic [W-1:0]  top,
    input  logic [W-1:0]  sec,
    input  logic [W-1:0]  mem_data,
    output logic [W-1:0]  val
);
    logic [AW-1:0] sec_slot;
    logic [AW-1:0] top_slot;

    assign sec_slot = sp + AW'(1);
    assign top_slot = sp + AW'(2);

    always_comb begin
        if (addr == top_slot) begin
            val = top;
        end else if (addr == sec_slot) begin
            val = sec;
        end else begin
            val = mem_data;
        end
    end
endmodule

// File: rtl/stack_core.sv
`timescale 1ns/1ps
module stack_core
    import stk_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_i,
    input  logic [2:0]    fn_i,
    input  logic [W-1:0]  push_data_i,
    input  logic [AW-1:0] vp_i,
    input  logic [AW-1:0] var_off_i,
    output logic [W-1:0]  tos_o,
    output logic [W-1:0]  nos_o,
    output logic [AW-1:0] sp_o
);
    stk_ctl_t      ctl;
    logic [W-1:0]  tos_q, nos_q, tos_d, nos_d;
    logic [AW-1:0] sp_q, sp_d, sp_up, sp_dn;
    logic [AW-1:0] lvar_addr, rd_addr;
    logic [W-1:0]  mem_rd, alu_y, lvar_val;

    assign ctl       = stk_decode(op_i);
    assign sp_up     = sp_q + AW'(1);
    assign sp_dn     = sp_q - AW'(1);
    assign lvar_addr = vp_i + var_off_i;
    assign rd_addr   = ctl.rd_local ? lvar_addr : sp_q;

    stk_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (ctl.spill),
        .waddr (sp_up),
        .wdata (nos_q),
        .raddr (rd_addr),
        .rdata (mem_rd)
    );

    stk_alu #(.W(W)) u_alu (
        .fn  (fn_i),
        .top (tos_q),
        .sec (nos_q),
        .y   (alu_y)
    );

    stk_lvar_sel #(.W(W), .DEPTH(DEPTH)) u_lvar (
        .addr     (lvar_addr),
        .sp       (sp_q),
        .top      (tos_q),
        .sec      (nos_q),
        .mem_data (mem_rd),
        .val      (lvar_val)
    );

    always_comb begin
        case (ctl.top_src)
            TSRC_ALU:  tos_d = alu_y;
            TSRC_PUSH: tos_d = push_data_i;
            TSRC_NOS:  tos_d = nos_q;
            TSRC_LVAR: tos_d = lvar_val;
            default:   tos_d = tos_q;
        endcase
        case (ctl.nos_src)
            NSRC_TOP: nos_d = tos_q;
            NSRC_MEM: nos_d = mem_rd;
            default:  nos_d = nos_q;
        endcase
        case (ctl.sp_step)
            SP_UP:   sp_d = sp_up;
            SP_DOWN: sp_d = sp_dn;
            default: sp_d = sp_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tos_q <= '0;
            nos_q <= '0;
            sp_q  <= '1;
        end else begin
            tos_q <= tos_d;
            nos_q <= nos_d;
            sp_q  <= sp_d;
        end
    end

    assign tos_o = tos_q;
    assign nos_o = nos_q;
    assign sp_o  = sp_q;
endmodule

// File: rtl/stack_core_chk.sv
`timescale 1ns/1ps
module stack_core_chk #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op_i,
    input logic [W-1:0]  push_data_i,
    input logic [AW-1:0] vp_i,
    input logic [AW-1:0] var_off_i,
    input logic [W-1:0]  tos_o,
    input logic [W-1:0]  nos_o,
    input logic [AW-1:0] sp_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (tos_o == '0 && nos_o == '0 && sp_o == '1));

    // R2
    push_move_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'd2 |=> (tos_o == $past(push_data_i) && nos_o == $past(tos_o)
                          && sp_o == AW'($past(sp_o) + AW'(1))));

    // R3
    pop_move_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'd3 |=> (tos_o == $past(nos_o) && sp_o == AW'($past(sp_o) - AW'(1))));

    // R4
    alu_sp_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'd1 |=> sp_o == AW'($past(sp_o) - AW'(1)));

    // R6
    lvar_sp_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 3'd4 |=> (nos_o == $past(tos_o) && sp_o == AW'($past(sp_o) + AW'(1))));

    // R7
    lvar_top_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && AW'(vp_i + var_off_i) == AW'(sp_o + AW'(2)))
        |=> tos_o == $past(tos_o));

    // R7
    lvar_sec_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && AW'(vp_i + var_off_i) == AW'(sp_o + AW'(1)))
        |=> tos_o == $past(nos_o));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0 || op_i > 3'd4) |=> ($stable(tos_o) && $stable(nos_o) && $stable(sp_o)));
endmodule

bind stack_core stack_core_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_i        (op_i),
    .push_data_i (push_data_i),
    .vp_i        (vp_i),
    .var_off_i   (var_off_i),
    .tos_o       (tos_o),
    .nos_o       (nos_o),
    .sp_o        (sp_o)
);

// File: tb/stack_core_test.sv
`timescale 1ns/1ps
module stack_core_test;
    localparam int TW  = 8;
    localparam int TD  = 8;
    localparam int TAW = $clog2(TD);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [2:0]     op_i = 3'd0;
    logic [2:0]     fn_i = 3'd0;
    logic [TW-1:0]  push_data_i = '0;
    logic [TAW-1:0] vp_i = '0;
    logic [TAW-1:0] var_off_i = '0;
    logic [TW-1:0]  tos_o, nos_o;
    logic [TAW-1:0] sp_o;

    int checks = 0;
    int failures = 0;
    logic [TW-1:0] m [0:31];
    int n = 2;

    always #2.5 clk = ~clk;

    stack_core #(.W(TW), .DEPTH(TD)) uut (
        .clk(clk), .rst(rst), .op_i(op_i), .fn_i(fn_i), .push_data_i(push_data_i),
        .vp_i(vp_i), .var_off_i(var_off_i), .tos_o(tos_o), .nos_o(nos_o), .sp_o(sp_o)
    );

    function automatic logic [TW-1:0] ref_fn(input int fn, input logic [TW-1:0] t,
                                             input logic [TW-1:0] s);
        case (fn)
            1: return s - t;
            2: return s & t;
            3: return s | t;
            4: return s ^ t;
            default: return s + t;
        endcase
    endfunction

    task automatic compare(input string req);
        logic [TAW-1:0] sp_exp;
        sp_exp = TAW'(n - 3);
        checks++;
        if (tos_o !== m[n-1] || nos_o !== m[n-2] || sp_o !== sp_exp) begin
            failures++;
            $display("FAIL %s: tos=%0h nos=%0h sp=%0d expected tos=%0h nos=%0h sp=%0d",
                     req, tos_o, nos_o, sp_o, m[n-1], m[n-2], sp_exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [2:0] fn,
                         input logic [TW-1:0] d, input logic [TAW-1:0] vp,
                         input logic [TAW-1:0] off);
        op_i = op; fn_i = fn; push_data_i = d; vp_i = vp; var_off_i = off;
        @(negedge clk);
        op_i = 3'd0;
    endtask

    task automatic do_push(input logic [TW-1:0] d, input string req);
        issue(3'd2, 3'd0, d, '0, '0);
        m[n] = d; n++;
        compare(req);
    endtask

    task automatic do_pop(input string req);
        checks++;
        if (tos_o !== m[n-1]) begin
            failures++;
            $display("FAIL %s: store value=%0h expected %0h", req, tos_o, m[n-1]);
        end
        issue(3'd3, 3'd0, '0, '0, '0);
        n--;
        compare(req);
    endtask

    task automatic do_alu(input int fn, input string req);
        logic [TW-1:0] r;
        r = ref_fn(fn, m[n-1], m[n-2]);
        issue(3'd1, 3'(fn), '0, '0, '0);
        n--; m[n-1] = r;
        compare(req);
    endtask

    task automatic do_lvar(input int vp, input int off, input string req);
        int a;
        a = (vp + off) % TD;
        issue(3'd4, 3'd0, '0, TAW'(vp), TAW'(off));
        m[n] = m[a]; n++;
        compare(req);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m[0] = '0; m[1] = '0; n = 2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        compare("R1");

        // R8 idle codes hold everything
        do_push(8'h3c, "R2");
        do_push(8'h5a, "R2");
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c > 4) begin
                issue(3'(c), 3'd0, 8'hff, '0, '0);
                compare("R8");
            end
        end
        do_pop("R3");
        do_pop("R3");

        // R4 / R5 sweep of function codes and operand pairs
        for (int fn = 0; fn < 8; fn++) begin
            for (int i = 0; i < 16; i++) begin
                do_push(TW'(i * 17), "R2");
                do_push(TW'(i * 53 + fn * 29), "R2");
                do_alu(fn, fn > 4 ? "R5_alias" : "R5_R4");
                do_pop("R3");
            end
        end

        // R9 fill memory to capacity then drain in LIFO order
        for (int k = 0; k < TD; k++) do_push(TW'(8'h91 + k * 7), "R9_fill");
        for (int k = 0; k < TD; k++) do_pop("R9_drain");

        // R6 / R7 local loads at depth TD-1
        for (int k = 0; k < TD - 3; k++) do_push(TW'(8'h20 + k * 11), "R2");
        for (int vp = 0; vp < TD; vp++) begin
            for (int off = 0; off < TD; off++) begin
                int a;
                a = (vp + off) % TD;
                if (a <= n - 1) begin
                    if (a == n - 1) do_lvar(vp, off, "R7_top");
                    else if (a == n - 2) do_lvar(vp, off, "R7_sec");
                    else do_lvar(vp, off, "R6");
                    do_pop("R3");
                end
            end
        end
        // local load feeding an ALU operation
        do_lvar(1, 2, "R6");
        do_alu(0, "R4");
        do_pop("R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule